// File: doc/BRIEF.md
# Tick-Driven Watchdog Timer

This block is a down-counting watchdog that advances on a slow tick of about 32 Hz taken from the real-time-clock oscillator. It counts only while the oscillator is reported as running. When the count runs out, it raises a sticky watchdog flag and, if enabled, an interrupt request. It then reloads and keeps counting, so a host that misses its service keeps getting new flags.

Software reaches it through a single 8-bit control register. That register holds a restart strobe, a write-lock bit and a 6-bit timeout measured in ticks. A timeout of zero turns the watchdog off. Reading the shared flags register clears the flag. The tick source and the shared interrupt pin driver are outside this block.

Top module: `tick_watchdog`

## Requirements
- R1: After reset the flag and the interrupt request are 0, the lock bit reads 0, the timeout reads the parameter `INIT_TIMEOUT`, and the counter is loaded with `INIT_TIMEOUT` and starts counting at once.
- R2: The counter steps down by one only in a cycle where `tick_i` and `osc_run_i` are both 1 and the stored timeout is non-zero. Ticks while the oscillator is stopped have no effect.
- R3: A tick that finds the counter at 1 or 0 is an expiry. The counter reloads from the timeout and keeps running, so with no service the flag is set again every `timeout` qualified ticks.
- R4: While the stored timeout is 0, no expiry happens and the flag is never set by the counter.
- R5: A register write with bit 7 (strobe) = 1 reloads the counter from the timeout in force after that write. Bit 7 always reads back as 0.
- R6: On a write, bits 5:0 (timeout) are taken only if the stored lock bit (bit 6) was 0 before the write. Otherwise the timeout keeps its old value. The lock bit is updated on every write. The readback `rd_data_o` is {0, lock, timeout}.
- R7: An expiry sets the flag in the following cycle. A flags read (`flags_rd_i`) clears it. If an expiry and a flags read fall in the same cycle, the flag ends up set.
- R8: `irq_o` is 1 exactly when the flag is 1 and `irq_en_i` is 1.
- R9: A strobe in the same cycle as a qualified tick wins. It reloads the counter, and that tick is neither counted nor able to cause an expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset (power-up) |
| tick_i | input | 1 | One-cycle pulse per 32 Hz period |
| osc_run_i | input | 1 | Oscillator running status |
| wr_en_i | input | 1 | Write strobe for the control register |
| wr_data_i | input | 8 | Write data: [7] strobe, [6] lock, [5:0] timeout |
| flags_rd_i | input | 1 | Flags-register read pulse, clears the flag |
| irq_en_i | input | 1 | Watchdog interrupt enable |
| wd_flag_o | output | 1 | Sticky watchdog flag |
| irq_o | output | 1 | Interrupt request |
| rd_data_o | output | 8 | Control register readback |

## Verification
Two pairs of events can land in the same cycle, and both are the ones that matter. One pair is a service strobe and the expiring tick. The other is a flags read and an expiry.

The bench sets up both on purpose. It programs a short timeout, walks the counter down to 1, and then issues the strobe or the flags read on the very cycle of the next tick. Long randomized traffic adds more such overlaps.

Each cycle is judged against a behavioural model that applies the stated priorities: strobe over tick, and set over clear. The flag, the interrupt and the readback are compared on every clock.

// File: rtl/wdt_pkg.sv
// Package: shared widths and field positions of the watchdog control register.
// Assumes the register is exactly strobe + lock + timeout bits wide.
package wdt_pkg;
    localparam int WDT_TO_W   = 6;
    localparam int WDT_REG_W  = WDT_TO_W + 2;
    localparam int WDT_BIT_STB = WDT_REG_W - 1;
    localparam int WDT_BIT_LCK = WDT_REG_W - 2;

    typedef logic [WDT_TO_W-1:0] wdt_to_t;

    typedef struct packed {
        logic    strobe;
        logic    lock;
        wdt_to_t timeout;
    } wdt_wr_t;
endpackage

// File: rtl/wdt_cfg_reg.sv
// Module: holds the lock bit and the timeout value of the watchdog.
// The timeout is taken on a write only when the stored lock bit is 0.
// Assumes one write per cycle at most; reset is synchronous, active low.
module wdt_cfg_reg
    import wdt_pkg::*;
#(
    parameter wdt_to_t INIT_TIMEOUT = wdt_to_t'(4)
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    wr_en_i,
    input  logic    wr_lock_i,
    input  wdt_to_t wr_timeout_i,
    output logic    lock_o,
    output wdt_to_t timeout_o,
    output wdt_to_t timeout_nxt_o
);
    logic    lock_q;
    wdt_to_t timeout_q;
    logic    accept;

    // Decide whether this write may change the timeout.
    always_comb begin
        accept        = wr_en_i && !lock_q;
        timeout_nxt_o = accept ? wr_timeout_i : timeout_q;
    end

    // Store the lock bit on every write and the gated timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q    <= 1'b0;
            timeout_q <= INIT_TIMEOUT;
        end else if (wr_en_i) begin
            lock_q    <= wr_lock_i;
            timeout_q <= timeout_nxt_o;
        end
    end

    assign lock_o    = lock_q;
    assign timeout_o = timeout_q;

    AST_LOCKED_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && lock_q) |=> $stable(timeout_q)); // R6
    AST_LOCK_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (lock_q == $past(wr_lock_i))); // R6
endmodule

// File: rtl/wdt_downcount.sv
// Module: the tick-driven down counter of the watchdog.
// A strobe takes priority over a tick in the same cycle. An expiry reloads
// the counter. Assumes tick_i is a single-cycle pulse.
module wdt_downcount
    import wdt_pkg::*;
#(
    parameter wdt_to_t INIT_TIMEOUT = wdt_to_t'(4)
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tick_i,
    input  logic    osc_run_i,
    input  logic    strobe_i,
    input  wdt_to_t timeout_i,
    input  wdt_to_t timeout_nxt_i,
    output logic    expire_o,
    output wdt_to_t count_o
);
    localparam wdt_to_t ONE = wdt_to_t'(1);

    wdt_to_t count_q;
    logic    enabled;
    logic    advance;

    // Qualify the tick and detect a count running out.
    always_comb begin
        enabled  = (timeout_i != '0);
        advance  = tick_i && osc_run_i && enabled && !strobe_i;
        expire_o = advance && (count_q <= ONE);
    end

    // Reload on strobe or expiry, otherwise step down on a qualified tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= INIT_TIMEOUT;
        end else if (strobe_i) begin
            count_q <= timeout_nxt_i;
        end else if (advance) begin
            count_q <= expire_o ? timeout_nxt_i : (count_q - ONE);
        end
    end

    assign count_o = count_q;

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && count_q > ONE) |=> (count_q == wdt_to_t'($past(count_q) - ONE))); // R2
    AST_HOLD_NO_OSC: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_run_i && !strobe_i) |=> $stable(count_q)); // R2
    AST_EXPIRE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> (count_q == $past(timeout_nxt_i))); // R3
    AST_STROBE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i |=> (count_q == $past(timeout_nxt_i))); // R9
endmodule

// File: rtl/wdt_flag.sv
// Module: sticky watchdog flag and the masked interrupt request.
// Set wins over a clearing flags read in the same cycle.
module wdt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic expire_i,
    input  logic flags_rd_i,
    input  logic irq_en_i,
    output logic flag_o,
    output logic irq_o
);
    logic flag_q;

    // Hold the flag until a flags read that does not meet a new expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (expire_i) begin
            flag_q <= 1'b1;
        end else if (flags_rd_i) begin
            flag_q <= 1'b0;
        end
    end

    // Gate the flag with the enable to form the request.
    always_comb begin
        irq_o = flag_q && irq_en_i;
    end

    assign flag_o = flag_q;

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> flag_q); // R7
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_rd_i && !expire_i) |=> !flag_q); // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flags_rd_i) |=> flag_q); // R7
endmodule

// File: rtl/tick_watchdog.sv
// Module: top of the tick-driven watchdog. Splits the control write into
// its fields and wires the config register, counter and flag logic together.
// Assumes the tick is synchronous to clk and lasts one cycle.
module tick_watchdog
    import wdt_pkg::*;
#(
    parameter wdt_to_t INIT_TIMEOUT = wdt_to_t'(4)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic                 osc_run_i,
    input  logic                 wr_en_i,
    input  logic [WDT_REG_W-1:0] wr_data_i,
    input  logic                 flags_rd_i,
    input  logic                 irq_en_i,
    output logic                 wd_flag_o,
    output logic                 irq_o,
    output logic [WDT_REG_W-1:0] rd_data_o
);
    wdt_wr_t wr_fields;
    logic    strobe;
    logic    lock;
    wdt_to_t timeout;
    wdt_to_t timeout_nxt;
    logic    expire;
    wdt_to_t count;

    // Decode the write into strobe, lock and timeout.
    always_comb begin
        wr_fields = wdt_wr_t'(wr_data_i);
        strobe    = wr_en_i && wr_fields.strobe;
    end

    wdt_cfg_reg #(.INIT_TIMEOUT(INIT_TIMEOUT)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_en_i),
        .wr_lock_i    (wr_fields.lock),
        .wr_timeout_i (wr_fields.timeout),
        .lock_o       (lock),
        .timeout_o    (timeout),
        .timeout_nxt_o(timeout_nxt)
    );

    wdt_downcount #(.INIT_TIMEOUT(INIT_TIMEOUT)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .osc_run_i    (osc_run_i),
        .strobe_i     (strobe),
        .timeout_i    (timeout),
        .timeout_nxt_i(timeout_nxt),
        .expire_o     (expire),
        .count_o      (count)
    );

    wdt_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .expire_i  (expire),
        .flags_rd_i(flags_rd_i),
        .irq_en_i  (irq_en_i),
        .flag_o    (wd_flag_o),
        .irq_o     (irq_o)
    );

    // Readback: the strobe position always reads 0.
    always_comb begin
        rd_data_o = {1'b0, lock, timeout};
    end

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout == '0) |-> !expire); // R4
    AST_NO_ORPHAN_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> wd_flag_o); // R8
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && wr_fields.timeout != '0 && !lock) |=> (count != '0)); // R5
endmodule

// File: tb/tick_watchdog_test.sv
module tick_watchdog_test;
    localparam int INIT = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick_i, osc_run_i, wr_en_i, flags_rd_i, irq_en_i;
    logic [7:0] wr_data_i;
    logic       wd_flag_o, irq_o;
    logic [7:0] rd_data_o;

    int    vectors = 0;
    int    fails   = 0;
    string cur_req = "R1";
    bit    done    = 1'b0;

    // behavioural model state
    int m_cnt, m_to, m_win, m_flag;

    always #5 clk = ~clk;

    tick_watchdog #(.INIT_TIMEOUT(6'(INIT))) uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .osc_run_i(osc_run_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .flags_rd_i(flags_rd_i),
        .irq_en_i(irq_en_i), .wd_flag_o(wd_flag_o), .irq_o(irq_o),
        .rd_data_o(rd_data_o)
    );

    task automatic compare();
        int exp_rd;
        exp_rd = (m_win << 6) | m_to;
        vectors++;
        if (wd_flag_o !== m_flag[0]) begin
            fails++;
            $display("FAIL %s/R7 flag act=%0d exp=%0d t=%0t", cur_req, wd_flag_o, m_flag, $time);
        end
        if (irq_o !== (m_flag[0] & irq_en_i)) begin
            fails++;
            $display("FAIL %s/R8 irq act=%0d exp=%0d t=%0t", cur_req, irq_o, m_flag[0] & irq_en_i, $time);
        end
        if (rd_data_o !== 8'(exp_rd)) begin
            fails++;
            $display("FAIL %s/R6 rdata act=%0h exp=%0h t=%0t", cur_req, rd_data_o, exp_rd, $time);
        end
    endtask

    // Apply one cycle of inputs, advance the model at the edge, compare after.
    task automatic step(input bit tk, input bit os, input bit wr, input int wd,
                        input bit rd, input bit en);
        int  to_next;
        bit  stb, adv, exp;
        tick_i = tk; osc_run_i = os; wr_en_i = wr; wr_data_i = 8'(wd);
        flags_rd_i = rd; irq_en_i = en;
        @(posedge clk);
        stb     = wr && wd[7];
        to_next = (wr && m_win == 0) ? (wd & 63) : m_to;
        adv     = tk && os && (m_to != 0) && !stb;
        exp     = adv && (m_cnt <= 1);
        if (stb) m_cnt = to_next;
        else if (adv) m_cnt = exp ? to_next : m_cnt - 1;
        if (exp) m_flag = 1;
        else if (rd) m_flag = 0;
        if (wr) begin
            m_win = wd[6];
            m_to  = to_next;
        end
        @(negedge clk);
        compare();
    endtask

    task automatic idle_ticks(input int n, input bit os, input bit en);
        for (int i = 0; i < n; i++) begin
            step(1, os, 0, 0, 0, en);
            step(0, os, 0, 0, 0, en);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; tick_i = 0; osc_run_i = 1; wr_en_i = 0; wr_data_i = 0;
        flags_rd_i = 0; irq_en_i = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_cnt = INIT; m_to = INIT; m_win = 0; m_flag = 0;
        cur_req = "R1"; compare();                      // R1 reset state
        // R2/R3: counts from INIT at once, expires, reloads and repeats
        cur_req = "R3"; idle_ticks(13, 1, 1);
        cur_req = "R7"; step(0, 1, 0, 0, 1, 1);        // clear by flags read
        // R2: oscillator stopped, ticks ignored
        cur_req = "R2"; idle_ticks(10, 0, 1);
        idle_ticks(3, 1, 0);                            // R8: masked irq
        // R5: strobe with timeout 2, lock 0
        cur_req = "R5"; step(0, 1, 1, 'h82, 1, 1);
        idle_ticks(1, 1, 1);
        // R9: strobe on the expiring tick
        cur_req = "R9"; step(1, 1, 1, 'h82, 0, 1);
        idle_ticks(1, 1, 1);
        // R7: flags read on the expiring tick, set wins
        cur_req = "R7"; step(1, 1, 0, 0, 1, 1);
        step(0, 1, 0, 0, 1, 1);
        // R6: lock behaviour
        cur_req = "R6";
        step(0, 1, 1, 'h49, 0, 1);                      // lock=1, to=9 accepted
        step(0, 1, 1, 'h14, 0, 1);                      // blocked, lock->0
        step(0, 1, 1, 'h1E | 'h40, 0, 1);               // to=30 accepted, lock=1
        step(0, 1, 1, 'h03, 0, 1);                      // blocked, lock->0
        step(0, 1, 1, 'h83, 0, 1);                      // to=3 + strobe
        idle_ticks(7, 1, 1);
        // R4: timeout 0 disables
        cur_req = "R4";
        step(0, 1, 1, 'h80, 1, 1);
        idle_ticks(80, 1, 1);
        step(0, 1, 1, 'h81, 0, 1);                      // back to 1: every tick
        idle_ticks(3, 1, 1);
        // randomized traffic
        cur_req = "R2";
        for (int i = 0; i < 20000; i++) begin
            int r;
            r = $urandom;
            step(r[1:0] == 0, r[7:4] != 0, r[12:8] == 0, $urandom & 255,
                 r[19:16] == 0, r[24]);
        end
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule